// File: doc/BRIEF.md
# Segmented DAC Input Path

This block is the digital front end of an 8-bit resistor-ladder converter whose upper range is split into equal segments. A data word first passes an inversion stage: with the invert control high every bit is flipped, with it low the word is untouched. The three top bits of the result are expanded into seven equally weighted bar-graph lines. The five low bits stay binary. All twelve lines then sit behind one level-sensitive hold stage that drives the ladder switches.

The hold stage is open while the active-low latch enable is low, so the lines follow the input. A rising edge on the enable freezes all twelve lines together, and they stay frozen while the enable is high. With the enable tied low the path runs without a clock. An active-low asynchronous reset clears every line. For checking, the block also rebuilds an 8-bit code from the held lines.

Top module: `segdac_front`

## Requirements
- R1: With `invert` high, the rebuilt code equals the bitwise inverse of `data_in` while the hold stage is open.
- R2: With `invert` low, the rebuilt code equals `data_in` unchanged while the hold stage is open.
- R3: `therm_out[k]` (k = 0..6) is 1 exactly when the top three bits of the inverted-or-passed word, read as an unsigned value, exceed k. The lines fill from bit 0 upward and never show a gap.
- R4: `low_out` equals bits 4..0 of the inverted-or-passed word, with bit 0 as the least significant.
- R5: `code_out` equals 32 times the number of set `therm_out` lines plus `low_out`. This holds across the segment boundaries 0x1F/0x20 and 0x7F/0x80.
- R6: While `latch_en_n` is low, a change on `data_in` or `invert` reaches the outputs with no edge needed.
- R7: A rising edge of `latch_en_n` holds the outputs. Later changes on `data_in` or `invert` do not affect them while `latch_en_n` stays high, including a change made in the same cycle as the edge.
- R8: While `rst_n` is low, all lines are 0 and `code_out` is 0x00, whatever `latch_en_n`, `invert` and `data_in` are.
- R9: When `rst_n` is released with `latch_en_n` low, the outputs follow the input at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low; clears the held lines |
| latch_en_n | input | 1 | Hold control, active low: low is open, a rising edge holds |
| invert | input | 1 | High inverts every data bit before encoding |
| data_in | input | 8 | Input word, bit 7 most significant |
| therm_out | output | 7 | Held bar-graph lines for the top three bits |
| low_out | output | 5 | Held binary lines for the five low bits |
| code_out | output | 8 | Code rebuilt from the held lines |

## Verification
Two things can land in the same cycle: the capture edge on `latch_en_n`, and a change of `data_in` together with a toggle of `invert`. The bench raises the enable shortly after a clock edge. A few nanoseconds later in the same cycle it applies a new word with the invert control flipped. The scoreboard expects the word that was present before the edge, and it keeps expecting that word through a further cycle of changing input. A reset pulse during the held phase is also judged: it must clear the lines even though the hold stage is closed.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DATA_W    = 8;
  localparam int SEG_W     = 3;
  localparam int LOW_W     = DATA_W - SEG_W;
  localparam int SEG_LINES = (1 << SEG_W) - 1;

  // Weight of one bar-graph line in LSB of the rebuilt code.
  localparam int SEG_WEIGHT = 1 << LOW_W;

  // Rebuild the binary code: count the set bar lines, then append the low bits.
  function automatic logic [DATA_W-1:0] rebuild_code(
    input logic [SEG_LINES-1:0] bars,
    input logic [LOW_W-1:0]     low
  );
    int n;
    logic [DATA_W-1:0] c;
    n = 0;
    for (int k = 0; k < SEG_LINES; k++) begin
      n = n + int'(bars[k]);
    end
    c = DATA_W'(n * SEG_WEIGHT) | DATA_W'(low);
    return c;
  endfunction
endpackage

// File: rtl/segdac_invert.sv
module segdac_invert #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic         inv,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign q[b] = d[b] ^ inv;
  end
endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
  parameter int SEG_W = 3,
  localparam int LINES = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0] seg,
  output logic [LINES-1:0] bars
);
  // Line k lights when the segment value exceeds k: bottom-up fill.
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign bars[k] = (seg > SEG_W'(k));
  end
endmodule

// File: rtl/segdac_hold.sv
module segdac_hold #(
  parameter int W = 12
) (
  input  logic         rst_n,
  input  logic         le_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // One vector for all lines so that they open and close together.
  always_latch begin
    if (!rst_n)     q = '0;
    else if (!le_n) q = d;
  end

  // Snapshot at the closing edge, used only by the hold check below.
  logic [W-1:0] snap_q;
  always_ff @(posedge le_n or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= d;
  end

  // R7: nothing moves the held lines while the enable is high.
  assert_hold_stable_R7: assert property (@(negedge le_n) disable iff (!rst_n)
    q == snap_q)
    else $error("held lines changed during the closed phase");

  // R8: reset leaves the lines cleared at the moment it is released.
  assert_reset_clears_R8: assert property (@(posedge rst_n)
    q == '0)
    else $error("lines not cleared by reset");
endmodule

// File: rtl/segdac_front.sv
module segdac_front
  import segdac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SEG_W,
  localparam int LW = DW - SW,
  localparam int NB = (1 << SW) - 1,
  localparam int NL = NB + LW
) (
  input  logic          rst_n,
  input  logic          latch_en_n,
  input  logic          invert,
  input  logic [DW-1:0] data_in,
  output logic [NB-1:0] therm_out,
  output logic [LW-1:0] low_out,
  output logic [DW-1:0] code_out
);
  logic [DW-1:0] word_c;
  logic [NB-1:0] bars_c;
  logic [NL-1:0] lines_d;
  logic [NL-1:0] lines_q;

  segdac_invert #(.W(DW)) i_inv (
    .d  (data_in),
    .inv(invert),
    .q  (word_c)
  );

  segdac_therm #(.SEG_W(SW)) i_therm (
    .seg (word_c[DW-1 -: SW]),
    .bars(bars_c)
  );

  assign lines_d = {bars_c, word_c[LW-1:0]};

  segdac_hold #(.W(NL)) i_hold (
    .rst_n(rst_n),
    .le_n (latch_en_n),
    .d    (lines_d),
    .q    (lines_q)
  );

  assign therm_out = lines_q[NL-1 -: NB];
  assign low_out   = lines_q[LW-1:0];
  assign code_out  = rebuild_code(therm_out, low_out);

  // R1 and R2: just before closing, the rebuilt code equals the conditioned input.
  assert_code_matches_R1: assert property (@(posedge latch_en_n) disable iff (!rst_n)
    code_out == (data_in ^ {DW{invert}}))
    else $error("rebuilt code differs from conditioned input");

  // R3: held bar lines never show a gap.
  assert_bars_gapless_R3: assert property (@(posedge latch_en_n) disable iff (!rst_n)
    int'(therm_out) == ((1 << $countones(therm_out)) - 1))
    else $error("bar-graph lines have a gap");
endmodule

// File: tb/test_segdac_front.sv
module test_segdac_front;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       latch_en_n = 1'b0;
  logic       invert = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [6:0] therm_out;
  logic [4:0] low_out;
  logic [7:0] code_out;

  segdac_front i_segdac_front (
    .rst_n(rst_n), .latch_en_n(latch_en_n), .invert(invert),
    .data_in(data_in), .therm_out(therm_out), .low_out(low_out),
    .code_out(code_out)
  );

  typedef struct {
    logic [6:0] therm;
    logic [4:0] low;
    logic [7:0] code;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [7:0] held = 8'h00;

  function automatic exp_t make_exp(logic [7:0] w, string req);
    exp_t e;
    int segs;
    segs = int'(w) / 32;
    e.therm = 7'((1 << segs) - 1);
    e.low   = 5'(w % 32);
    e.code  = 8'(segs * 32 + int'(w % 32));
    e.req   = req;
    return e;
  endfunction

  task automatic step(logic r, logic l, logic i, logic [7:0] d, string req);
    @(posedge clk); #1;
    rst_n = r; latch_en_n = l; invert = i; data_in = d;
    if (!r) held = 8'h00;
    else if (!l) held = i ? ~d : d;
    q.push_back(make_exp(held, req));
  endtask

  // Close the hold stage, then change data and invert later in the same cycle.
  task automatic close_then_change(logic i, logic [7:0] d, string req);
    @(posedge clk); #1;
    latch_en_n = 1'b1;
    #2;
    invert = i; data_in = d;
    q.push_back(make_exp(held, req));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (therm_out !== e.therm || low_out !== e.low || code_out !== e.code) begin
        n_fail++;
        $display("FAIL %s: got therm=%b low=%h code=%h, expected therm=%b low=%h code=%h",
                 e.req, therm_out, low_out, code_out, e.therm, e.low, e.code);
      end
    end
  end

  initial begin
    // R8: reset clears regardless of the open enable and the data.
    step(0, 0, 0, 8'hA5, "R8 reset clear");
    step(0, 0, 1, 8'h3C, "R8 reset ignores data");
    // R9: release with enable low follows at once.
    step(1, 0, 0, 8'h00, "R9 release follows zero");
    step(1, 0, 0, 8'hFF, "R2 R3 full scale");
    step(1, 0, 1, 8'h5A, "R1 inverted word");
    // R3 R4: every segment value with varied low bits and both invert settings.
    for (int k = 0; k < 8; k++) begin
      step(1, 0, k[0], 8'((k * 32 + k * 3) ^ (k[0] ? 8'hFF : 8'h00)), "R3 R4 segment sweep");
    end
    // R5: segment boundaries.
    step(1, 0, 0, 8'h1F, "R5 below 0x20");
    step(1, 0, 0, 8'h20, "R5 at 0x20");
    step(1, 0, 1, 8'h80, "R5 inverted 0x7F");
    step(1, 0, 1, 8'h7F, "R5 inverted 0x80");
    // R6: open stage follows a fresh word.
    step(1, 0, 0, 8'h47, "R6 transparent");
    // R7: close edge and input change in the same cycle.
    close_then_change(1, 8'h90, "R7 same-cycle change ignored");
    step(1, 1, 0, 8'h12, "R7 held through next cycle");
    // R8: reset during the closed phase still clears.
    step(0, 1, 0, 8'h12, "R8 reset while closed");
    step(1, 1, 1, 8'hC3, "R8 cleared lines stay held");
    // R6: reopening shows the current input.
    step(1, 0, 1, 8'hC3, "R6 reopen follows input");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule